// File: doc/BRIEF.md
# Bicolor Status LED Driver

This block turns four encoded status values into light patterns on four red/green LED pairs. Each pair shows a solid colour, a fast flash, a slow blink, or an imitation of "both colours on" made by swapping red and green every few milliseconds, so the two dies of one pair are never driven together. The four inputs are a security state, a battery condition, a processor busy percentage and a general run state. Each input has its own pair.

All patterns come from one shared time base. A prescaler makes a base tick, and a single phase counter spans one slow-blink period in ticks. The flash, blink and swap phases are all read from that one counter, so any two pairs that show the same pattern switch on the same cycle. Each pair's enables are registered once, so the outputs change exactly one clock after an input or a phase change.

Lane order on the output vectors: bit 0 security, bit 1 battery, bit 2 busy, bit 3 general.

Top module: `led_status_driver`

## Requirements
- R1: While rst_n is low at a rising edge, all red and green enables are 0 after that edge. The phase counter restarts at tick 0 when reset is released.
- R2: The security lane (bit 0) maps its code as follows: code 0 gives solid green, code 1 gives fast-flashing red, and code 2 gives slow-blinking green.
- R3: The battery lane (bit 1) maps its code as follows: code 0 gives solid green, code 1 gives red/green alternation, code 2 gives solid red, and code 3 gives fast-flashing red.
- R4: The busy lane (bit 2) shows solid green for busy_pct below BUSY_THRESH (default 50), which includes 0. It shows fast-flashing red for BUSY_THRESH and above, which includes 100.
- R5: The general lane (bit 3) maps its code as follows: code 0 gives off, code 1 gives fast-flashing green, code 2 gives solid green, and code 3 gives fast-flashing red.
- R6: Pattern timing. One tick lasts TICK_CYCLES clocks. The phase runs from 0 to 2*SLOW_TICKS-1 and then wraps. A fast flash is lit for FAST_TICKS ticks starting at phase 0, then dark for FAST_TICKS ticks. A slow blink is lit while the phase is below SLOW_TICKS. Alternation shows red for ALT_TICKS ticks starting at phase 0, then green for ALT_TICKS ticks.
- R7: Lanes that show the same pattern have identical enables on every cycle.
- R8: A lane never has its red and green enables both at 1 in the same cycle.
- R9: An input change appears on the outputs at the first rising edge after the change, and not before that edge.
- R10: Unlisted or out-of-range values are handled as follows: security code 3 gives fast-flashing red, and a busy_pct above 100 gives fast-flashing red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_code | input | 2 | Security state code |
| batt_code | input | 2 | Battery condition code |
| busy_pct | input | BUSY_W (7) | Busy level, 0 to 100 percent |
| gen_code | input | 2 | General run state code |
| led_red | output | 4 | Red enables, one per lane |
| led_grn | output | 4 | Green enables, one per lane |

## Verification
Every output is due one rising edge after the inputs and phase that produce it. The phase is the number of whole ticks in the edges after reset, minus one edge. The bench counts rising edges from reset release, drives inputs only at falling edges, and samples at the next falling edge. It computes the expected phase from that edge count, so each comparison refers to exactly one register update. The latency test also samples just after an input change, before any edge, to confirm that the outputs have not moved yet.

// File: rtl/led_status_pkg.sv
// Shared types for the bicolor status LED driver.
// Assumes four lanes in a fixed order: security, battery, busy, general.
package led_status_pkg;

    localparam int LANES     = 4;
    localparam int LANE_SEC  = 0;
    localparam int LANE_BATT = 1;
    localparam int LANE_BUSY = 2;
    localparam int LANE_GEN  = 3;

    // Light pattern selected for one LED pair
    typedef enum logic [2:0] {
        PAT_OFF      = 3'd0,
        PAT_GRN      = 3'd1,
        PAT_RED      = 3'd2,
        PAT_GRN_FAST = 3'd3,
        PAT_RED_FAST = 3'd4,
        PAT_GRN_SLOW = 3'd5,
        PAT_ALT      = 3'd6
    } led_pat_e;

    // Phase-derived enables shared by every lane
    typedef struct packed {
        logic fast_on;   // fast flash lit half
        logic slow_on;   // slow blink lit half
        logic alt_red;   // alternation shows red
    } phase_flags_t;

    // True when the phase sits in an odd-numbered window of width half_len
    function automatic logic odd_window(input int unsigned ph, input int unsigned half_len);
        return ((ph / half_len) % 2) == 1;
    endfunction

endpackage

// File: rtl/led_phase_gen.sv
// Shared time base: a prescaler that makes one tick every TICK_CYCLES
// clocks, and one phase counter spanning a full slow-blink period.
// Assumes 2*SLOW_TICKS is a multiple of 2*FAST_TICKS and of 2*ALT_TICKS,
// so every pattern wraps cleanly together with the counter.
module led_phase_gen
    import led_status_pkg::*;
#(
    parameter int TICK_CYCLES = 100_000,
    parameter int ALT_TICKS   = 2,
    parameter int FAST_TICKS  = 125,
    parameter int SLOW_TICKS  = 500
) (
    input  logic         clk,
    input  logic         rst_n,
    output phase_flags_t flags
);
    localparam int PERIOD = 2 * SLOW_TICKS;
    localparam int PHW    = $clog2(PERIOD);
    localparam int PSW    = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

    logic [PSW-1:0] pre_q;
    logic [PHW-1:0] phase_q;
    logic           tick;

    assign tick = (pre_q == PSW'(TICK_CYCLES - 1));

    // Prescaler: counts clocks within one tick
    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // Phase counter: advances once per tick and wraps after one period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (tick) begin
            if (phase_q == PHW'(PERIOD - 1)) phase_q <= '0;
            else                             phase_q <= phase_q + 1'b1;
        end
    end

    // Decode the shared phase into the three pattern enables
    always_comb begin
        flags.fast_on = !odd_window(int'(phase_q), FAST_TICKS);
        flags.slow_on = (phase_q < PHW'(SLOW_TICKS));
        flags.alt_red = !odd_window(int'(phase_q), ALT_TICKS);
    end

endmodule

// File: rtl/led_code_map.sv
// Maps each encoded status input onto a light pattern for its lane.
// Purely combinational. Busy values at or above BUSY_THRESH, including
// values above 100, select fast red.
module led_code_map
    import led_status_pkg::*;
#(
    parameter int BUSY_W      = 7,
    parameter int BUSY_THRESH = 50
) (
    input  logic [1:0]        sec_code,
    input  logic [1:0]        batt_code,
    input  logic [BUSY_W-1:0] busy_pct,
    input  logic [1:0]        gen_code,
    output led_pat_e          pats [LANES]
);
    // Security state decode
    always_comb begin
        unique case (sec_code)
            2'd0:    pats[LANE_SEC] = PAT_GRN;
            2'd2:    pats[LANE_SEC] = PAT_GRN_SLOW;
            default: pats[LANE_SEC] = PAT_RED_FAST;
        endcase
    end

    // Battery condition decode
    always_comb begin
        unique case (batt_code)
            2'd0:    pats[LANE_BATT] = PAT_GRN;
            2'd1:    pats[LANE_BATT] = PAT_ALT;
            2'd2:    pats[LANE_BATT] = PAT_RED;
            default: pats[LANE_BATT] = PAT_RED_FAST;
        endcase
    end

    // Busy level threshold
    always_comb begin
        if (busy_pct < BUSY_W'(BUSY_THRESH)) pats[LANE_BUSY] = PAT_GRN;
        else                                 pats[LANE_BUSY] = PAT_RED_FAST;
    end

    // General run state decode
    always_comb begin
        unique case (gen_code)
            2'd0:    pats[LANE_GEN] = PAT_OFF;
            2'd1:    pats[LANE_GEN] = PAT_GRN_FAST;
            2'd2:    pats[LANE_GEN] = PAT_GRN;
            default: pats[LANE_GEN] = PAT_RED_FAST;
        endcase
    end

endmodule

// File: rtl/led_pattern_render.sv
// Renders each lane's pattern against the shared phase flags into
// registered red/green enables. One flop stage per colour per lane.
// Assumes flags come from a single phase counter, so lanes stay in step.
module led_pattern_render
    import led_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  phase_flags_t     flags,
    input  led_pat_e         pats [LANES],
    output logic [LANES-1:0] red,
    output logic [LANES-1:0] grn
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic r_nx, g_nx, r_q, g_q;

        // Pattern-to-colour decode for this lane
        always_comb begin
            r_nx = 1'b0;
            g_nx = 1'b0;
            unique case (pats[l])
                PAT_GRN:      g_nx = 1'b1;
                PAT_RED:      r_nx = 1'b1;
                PAT_GRN_FAST: g_nx = flags.fast_on;
                PAT_RED_FAST: r_nx = flags.fast_on;
                PAT_GRN_SLOW: g_nx = flags.slow_on;
                PAT_ALT: begin
                    r_nx = flags.alt_red;
                    g_nx = !flags.alt_red;
                end
                default: ;
            endcase
        end

        // Output register for this lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= 1'b0;
                g_q <= 1'b0;
            end else begin
                r_q <= r_nx;
                g_q <= g_nx;
            end
        end

        assign red[l] = r_q;
        assign grn[l] = g_q;
    end

endmodule

// File: rtl/led_status_driver.sv
// Top of the bicolor status LED driver. It joins the shared time base,
// the code-to-pattern map and the per-lane renderer. Lane order on
// led_red/led_grn: 0 security, 1 battery, 2 busy, 3 general.
// Outputs are registered, one clock after inputs.
module led_status_driver
    import led_status_pkg::*;
#(
    parameter int TICK_CYCLES = 100_000,
    parameter int ALT_TICKS   = 2,
    parameter int FAST_TICKS  = 125,
    parameter int SLOW_TICKS  = 500,
    parameter int BUSY_W      = 7,
    parameter int BUSY_THRESH = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sec_code,
    input  logic [1:0]        batt_code,
    input  logic [BUSY_W-1:0] busy_pct,
    input  logic [1:0]        gen_code,
    output logic [3:0]        led_red,
    output logic [3:0]        led_grn
);
    phase_flags_t flags;
    led_pat_e     pats [LANES];

    led_phase_gen #(
        .TICK_CYCLES(TICK_CYCLES),
        .ALT_TICKS  (ALT_TICKS),
        .FAST_TICKS (FAST_TICKS),
        .SLOW_TICKS (SLOW_TICKS)
    ) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .flags(flags)
    );

    led_code_map #(
        .BUSY_W     (BUSY_W),
        .BUSY_THRESH(BUSY_THRESH)
    ) u_map (
        .sec_code (sec_code),
        .batt_code(batt_code),
        .busy_pct (busy_pct),
        .gen_code (gen_code),
        .pats     (pats)
    );

    led_pattern_render u_render (
        .clk  (clk),
        .rst_n(rst_n),
        .flags(flags),
        .pats (pats),
        .red  (led_red),
        .grn  (led_grn)
    );

endmodule

// File: rtl/led_status_driver_chk.sv
// Property checker for led_status_driver, attached by bind below.
// Observes ports only.
module led_status_driver_chk #(
    parameter int BUSY_W      = 7,
    parameter int BUSY_THRESH = 50
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        sec_code,
    input logic [1:0]        batt_code,
    input logic [BUSY_W-1:0] busy_pct,
    input logic [1:0]        gen_code,
    input logic [3:0]        led_red,
    input logic [3:0]        led_grn
);
    // Reset clears every enable
    p_reset_dark_r1: assert property (@(posedge clk)
        !rst_n |=> (led_red == 4'd0 && led_grn == 4'd0));

    // Secure state is solid green on the next edge
    p_secure_green_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_code == 2'd0) |=> (led_grn[0] && !led_red[0]));

    // Critical battery is solid red on the next edge
    p_batt_critical_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (batt_code == 2'd2) |=> (led_red[1] && !led_grn[1]));

    // Busy below threshold is solid green on the next edge
    p_busy_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_pct < BUSY_W'(BUSY_THRESH)) |=> (led_grn[2] && !led_red[2]));

    // Idle general state is dark on the next edge
    p_gen_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_code == 2'd0) |=> (!led_grn[3] && !led_red[3]));

    // Same fast-red pattern on security and general lanes stays in step
    p_lanes_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_code == 2'd1 && gen_code == 2'd3) |=> (led_red[0] == led_red[3]));

    // Never both colours on one pair
    for (genvar l = 0; l < 4; l++) begin : g_excl
        p_one_colour_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(led_red[l] && led_grn[l]));
    end

endmodule

bind led_status_driver led_status_driver_chk #(
    .BUSY_W     (BUSY_W),
    .BUSY_THRESH(BUSY_THRESH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_code (sec_code),
    .batt_code(batt_code),
    .busy_pct (busy_pct),
    .gen_code (gen_code),
    .led_red  (led_red),
    .led_grn  (led_grn)
);

// File: tb/led_status_driver_test.sv
// Directed bench for led_status_driver with a shortened time base.
module led_status_driver_test;
    localparam int TC     = 2;
    localparam int ALT    = 2;
    localparam int FAST   = 5;
    localparam int SLOW   = 20;
    localparam int PERIOD = 2 * SLOW;
    localparam int FULL   = PERIOD * TC;   // clocks per phase period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sec_code = 2'd0;
    logic [1:0] batt_code = 2'd0;
    logic [6:0] busy_pct = 7'd0;
    logic [1:0] gen_code = 2'd0;
    logic [3:0] led_red, led_grn;

    int n_checks = 0;
    int n_fails  = 0;
    int edges    = 0;
    bit done     = 0;

    led_status_driver #(
        .TICK_CYCLES(TC), .ALT_TICKS(ALT), .FAST_TICKS(FAST), .SLOW_TICKS(SLOW),
        .BUSY_W(7), .BUSY_THRESH(50)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sec_code(sec_code), .batt_code(batt_code),
        .busy_pct(busy_pct), .gen_code(gen_code), .led_red(led_red), .led_grn(led_grn)
    );

    always #5 clk = ~clk;

    // Rising edges since reset release
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    // Pattern codes: 0 off, 1 green, 2 red, 3 green fast, 4 red fast, 5 green slow, 6 alternate
    function automatic int pat_sec(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd2) ? 5 : 4;   // R2, R10
    endfunction
    function automatic int pat_batt(input logic [1:0] c);
        case (c) 2'd0: return 1; 2'd1: return 6; 2'd2: return 2; default: return 4; endcase  // R3
    endfunction
    function automatic int pat_busy(input logic [6:0] b);
        return (b < 7'd50) ? 1 : 4;                      // R4, R10
    endfunction
    function automatic int pat_gen(input logic [1:0] c);
        case (c) 2'd0: return 0; 2'd1: return 3; 2'd2: return 1; default: return 4; endcase  // R5
    endfunction

    // Red/green pair for a pattern at a phase, per R6
    function automatic logic [1:0] rg(input int p, input int ph);
        logic fast_lit, slow_lit, alt_r;
        fast_lit = ((ph / FAST) % 2) == 0;
        slow_lit = ph < SLOW;
        alt_r    = ((ph / ALT) % 2) == 0;
        case (p)
            1: return 2'b01;
            2: return 2'b10;
            3: return {1'b0, fast_lit};
            4: return {fast_lit, 1'b0};
            5: return {1'b0, slow_lit};
            6: return {alt_r, !alt_r};
            default: return 2'b00;
        endcase
    endfunction

    // Compare all four lanes with the model at the current sample point
    task automatic check_now(input string tag);
        int ph;
        logic [3:0] er, eg;
        logic [1:0] v;
        ph = ((edges - 1) / TC) % PERIOD;
        v = rg(pat_sec(sec_code), ph);   er[0] = v[1]; eg[0] = v[0];
        v = rg(pat_batt(batt_code), ph); er[1] = v[1]; eg[1] = v[0];
        v = rg(pat_busy(busy_pct), ph);  er[2] = v[1]; eg[2] = v[0];
        v = rg(pat_gen(gen_code), ph);   er[3] = v[1]; eg[3] = v[0];
        n_checks++;
        if (led_red !== er || led_grn !== eg) begin
            n_fails++;
            $display("FAIL %s (phase %0d): red=%b grn=%b expected red=%b grn=%b",
                     tag, ph, led_red, led_grn, er, eg);
        end
    endtask

    // Run n cycles, checking at every falling edge
    task automatic run_check(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check_now(tag);
        end
    endtask

    task automatic expect_bits(input logic [3:0] r, input logic [3:0] g, input string tag);
        n_checks++;
        if (led_red !== r || led_grn !== g) begin
            n_fails++;
            $display("FAIL %s: red=%b grn=%b expected red=%b grn=%b", tag, led_red, led_grn, r, g);
        end
    endtask

    task automatic t_reset;   // R1
        sec_code = 2'd1; batt_code = 2'd3; busy_pct = 7'd100; gen_code = 2'd2;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_bits(4'b0000, 4'b0000, "R1 outputs dark in reset");
        rst_n = 1'b1;
        run_check(FULL, "R1 phase restarts at 0 after reset");
    endtask

    task automatic t_security;   // R2, R6
        for (int c = 0; c < 3; c++) begin
            sec_code = 2'(c);
            run_check(FULL, "R2 security pattern");
        end
    endtask

    task automatic t_battery;   // R3, R6
        for (int c = 0; c < 4; c++) begin
            batt_code = 2'(c);
            run_check(FULL, "R3 battery pattern");
        end
    endtask

    task automatic t_busy;   // R4, R10
        busy_pct = 7'd0;   run_check(FULL, "R4 busy 0");
        busy_pct = 7'd49;  run_check(FULL, "R4 busy 49");
        busy_pct = 7'd50;  run_check(FULL, "R4 busy 50");
        busy_pct = 7'd100; run_check(FULL, "R4 busy 100");
        busy_pct = 7'd127; run_check(FULL, "R10 busy above 100");
    endtask

    task automatic t_general;   // R5, R6
        for (int c = 0; c < 4; c++) begin
            gen_code = 2'(c);
            run_check(FULL, "R5 general pattern");
        end
    endtask

    task automatic t_sync_excl;   // R7, R8, R10
        sec_code = 2'd3; batt_code = 2'd3; busy_pct = 7'd80; gen_code = 2'd3;
        for (int i = 0; i < FULL; i++) begin
            @(posedge clk);
            @(negedge clk);
            n_checks++;
            if (!(led_red == 4'b1111 || led_red == 4'b0000) || led_grn !== 4'b0000) begin
                n_fails++;
                $display("FAIL R7 lanes out of step: red=%b grn=%b expected red=1111 or 0000 grn=0000",
                         led_red, led_grn);
            end
        end
        batt_code = 2'd1; sec_code = 2'd0; busy_pct = 7'd0; gen_code = 2'd2;
        for (int i = 0; i < FULL; i++) begin
            @(posedge clk);
            @(negedge clk);
            n_checks++;
            if ((led_red & led_grn) !== 4'b0000) begin
                n_fails++;
                $display("FAIL R8 both colours on: red=%b grn=%b expected overlap=0000", led_red, led_grn);
            end
        end
    endtask

    task automatic t_latency;   // R9
        logic [3:0] r0, g0;
        sec_code = 2'd0; batt_code = 2'd0; busy_pct = 7'd0; gen_code = 2'd0;
        run_check(2, "R9 settle");
        r0 = led_red; g0 = led_grn;
        batt_code = 2'd2; gen_code = 2'd2;
        #1;
        expect_bits(r0, g0, "R9 no change before edge");
        @(posedge clk);
        @(negedge clk);
        check_now("R9 change after one edge");
    endtask

    task automatic t_midrun_reset;   // R1, R6
        gen_code = 2'd1; sec_code = 2'd2;
        run_check(37, "R6 before second reset");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        expect_bits(4'b0000, 4'b0000, "R1 mid-run reset dark");
        rst_n = 1'b1;
        run_check(FULL + 10, "R6 phase after second reset");
    endtask

    // Watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_security();
        t_battery();
        t_busy();
        t_general();
        t_sync_excl();
        t_latency();
        t_midrun_reset();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule